// File: doc/BRIEF.md
# UART Receive Word Packer with Idle Timeout

This block sits between a UART character receiver and a 32-bit receive FIFO. Each accepted 8-bit character goes into the next free byte lane of a word under assembly. A completed word is pushed to the FIFO. The block counts the characters of the current transfer and decides when the transfer has ended. It ends a transfer in one of two ways: the line stays quiet for a programmable number of character times, or the character count reaches an expected length that software has armed.

When a transfer ends, any partly filled word is pushed at once, with its unused upper lanes set to zero. The character count is copied into a snapshot that software reads to learn how many bytes of the last word are valid. Software starts and stops the receiver, and enables, disables and acknowledges the end-of-transfer event, through a 3-bit command strobe. A character that meets a full FIFO is dropped and sets a sticky overrun flag.

Top module: `uart_rx_packer`

## Requirements
- R1: The first character of a word lands in bits [7:0], and each later character takes the next higher byte. The fourth character of a word causes a push of the full word on `fifo_push`/`fifo_data` one cycle after it is accepted.
- R2: The idle timer advances on each `char_tick` cycle and restarts on every accepted character, which wins over a tick in the same cycle. The transfer ends on the `stale_limit`-th tick after the last accepted character. A limit of 0 behaves as 1.
- R3: The idle timer runs only while stale events are enabled and at least one character of the transfer is unreported. `stale_evt` is set only at a transfer end while enabled, and stays set until command 6 (clear event). Command 4 enables stale events and command 5 disables them.
- R4: At a transfer end, a partly filled word is pushed with zeros in its unused upper lanes. No push occurs when no lanes are filled.
- R5: At each transfer end, `snap_count` takes the number of characters accepted since the previous end, including a character accepted in the ending cycle. The counter then restarts from zero.
- R6: A `len_wr` pulse with a non-zero `len_val` arms a limit. The character that brings the count to `len_val` ends the transfer with no wait for the timer. A transfer end disarms the limit, and a value of 0 leaves the limit disarmed.
- R7: A character that arrives while the receiver is enabled and `fifo_full` is high is dropped, is not counted, and sets `overrun`. `overrun` stays set until command 7 (clear error).
- R8: Command 1 (reset receive path) discards the partial word, the count, the armed limit and the timer, and disables the receiver. Characters are accepted only after command 2 (enable), and command 3 disables the receiver again.
- R9: After reset, `fifo_push`, `fifo_data`, `stale_evt`, `snap_count` and `overrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a received character is present |
| char_data | input | 8 | Received character |
| char_tick | input | 1 | One pulse per character time, for the idle timer |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 1 rx reset, 2 rx on, 3 rx off, 4 stale on, 5 stale off, 6 clear event, 7 clear error |
| stale_limit | input | 8 | Idle timeout in character times |
| len_wr | input | 1 | Arms the expected-length limit |
| len_val | input | 16 | Expected transfer length in characters |
| fifo_full | input | 1 | Downstream FIFO cannot take a character |
| fifo_push | output | 1 | Push strobe to the FIFO |
| fifo_data | output | 32 | Packed word |
| stale_evt | output | 1 | Sticky end-of-transfer event |
| snap_count | output | 16 | Characters in the last ended transfer |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
The bench checks the exact tick on which the timeout fires, one tick early and on time. A design whose timer is off by one would flag the end a tick early or late, and one that ignored character restarts would end mid-stream. Transfers of 1, 3, 4, 5, 6 and 8 characters test the lane order and the zero fill of the partial word. A design that held a partial word back would push too few words, and one that kept stale bytes would show garbage in the upper lanes. A length-limited transfer and a second, unarmed transfer check that the limit ends the transfer without ticks and then disarms itself. A receive reset, a dropped character under a full FIFO and a disabled timer are each checked by the words and count seen afterwards.

// File: rtl/uart_rx_pkg.sv
// Shared command codes for the receive word packer.
package uart_rx_pkg;
    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_RX_RESET  = 3'd1,
        CMD_RX_ON     = 3'd2,
        CMD_RX_OFF    = 3'd3,
        CMD_STALE_ON  = 3'd4,
        CMD_STALE_OFF = 3'd5,
        CMD_STALE_CLR = 3'd6,
        CMD_ERR_CLR   = 3'd7
    } rx_cmd_e;
endpackage

// File: rtl/rx_word_packer.sv
// Packs characters into words, earliest character in the lowest lane.
// Pushes a word when it is full or when a flush is requested with lanes filled.
// Assumes accept and flush come from the same cycle's control decision.
module rx_word_packer #(
    parameter int CHAR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              accept,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              flush,
    output logic              push,
    output logic [WORD_W-1:0] word_out
);
    localparam int LANES = WORD_W / CHAR_W;
    localparam int IDX_W = $clog2(LANES + 1);

    logic [IDX_W-1:0]  fill_q;
    logic [IDX_W-1:0]  fill_nx;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_nx;
    logic              do_push;
    logic              push_q;
    logic [WORD_W-1:0] data_q;

    // Lane write: the incoming character lands in the lane given by the fill level.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_nx[g*CHAR_W +: CHAR_W] =
            (accept && (fill_q == IDX_W'(g))) ? char_in : word_q[g*CHAR_W +: CHAR_W];
    end

    // Push decision: full word, or flush with at least one lane filled.
    always_comb begin
        fill_nx = fill_q + IDX_W'(accept);
        do_push = (fill_nx == IDX_W'(LANES)) || (flush && (fill_nx != '0));
    end

    // Assembly register and output register; a pushed word leaves zeros behind.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fill_q <= '0;
            word_q <= '0;
            push_q <= 1'b0;
            data_q <= '0;
        end else begin
            push_q <= do_push;
            if (do_push) begin
                data_q <= word_nx;
                word_q <= '0;
                fill_q <= '0;
            end else begin
                word_q <= word_nx;
                fill_q <= fill_nx;
            end
        end
    end

    assign push     = push_q;
    assign word_out = data_q;
endmodule

// File: rtl/rx_stale_timer.sv
// Counts character-time ticks since the last accepted character.
// Fires expire on the tick that reaches the limit; a limit of 0 acts as 1.
// Assumes run is low when nothing is pending or events are disabled.
module rx_stale_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             char_seen,
    input  logic             tick,
    input  logic [TMR_W-1:0] limit,
    output logic             expire
);
    logic [TMR_W-1:0] t_q;
    logic [TMR_W-1:0] lim_eff;
    logic [TMR_W:0]   t_inc;

    // Expiry compare against the effective limit.
    always_comb begin
        lim_eff = (limit == '0) ? TMR_W'(1) : limit;
        t_inc   = {1'b0, t_q} + (TMR_W+1)'(1);
        expire  = run && tick && !char_seen && (t_inc >= {1'b0, lim_eff});
    end

    // Tick counter: restarts on characters, expiry, idle or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || char_seen || expire || !run) begin
            t_q <= '0;
        end else if (tick) begin
            t_q <= t_inc[TMR_W-1:0];
        end
    end
endmodule

// File: rtl/rx_xfer_counter.sv
// Counts characters of the current transfer, applies the armed length limit,
// and copies the count into the snapshot when the transfer ends.
// Assumes expire is never high in a cycle with an accepted character.
module rx_xfer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic             expire,
    input  logic             len_wr,
    input  logic [CNT_W-1:0] len_val,
    output logic             xfer_end,
    output logic             pending,
    output logic [CNT_W-1:0] snap
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] len_q;
    logic             armed_q;
    logic [CNT_W-1:0] snap_q;
    logic             hit;

    // End detection: armed length reached, or idle timer expiry.
    always_comb begin
        hit      = armed_q && accept && ((count_q + CNT_W'(1)) == len_q);
        xfer_end = !clear && (hit || expire);
        pending  = (count_q != '0);
    end

    // Count, limit and snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            len_q   <= '0;
            armed_q <= 1'b0;
            snap_q  <= '0;
        end else if (clear) begin
            count_q <= '0;
            len_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (xfer_end) begin
                snap_q  <= count_q + CNT_W'(accept);
                count_q <= '0;
                armed_q <= 1'b0;
            end else if (accept) begin
                count_q <= count_q + CNT_W'(1);
            end
            if (len_wr) begin
                len_q   <= len_val;
                armed_q <= (len_val != '0);
            end
        end
    end

    assign snap = snap_q;
endmodule

// File: rtl/uart_rx_packer.sv
// Receive word packer: decodes commands, gates characters, and ties together
// the packer, idle timer and transfer counter. Holds the enable, event and
// overrun flags. Assumes char_valid is at most one cycle per character.
module uart_rx_packer
    import uart_rx_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              char_tick,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [TMR_W-1:0]  stale_limit,
    input  logic              len_wr,
    input  logic [CNT_W-1:0]  len_val,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_data,
    output logic              stale_evt,
    output logic [CNT_W-1:0]  snap_count,
    output logic              overrun
);
    logic rx_en_q;
    logic stale_en_q;
    logic stale_q;
    logic ovr_q;
    logic rx_rst;
    logic accept;
    logic drop;
    logic expire;
    logic xfer_end;
    logic pending;

    // Command decode and character gating.
    always_comb begin
        rx_rst = cmd_valid && (cmd_code == CMD_RX_RESET);
        accept = char_valid && rx_en_q && !fifo_full && !rx_rst;
        drop   = char_valid && rx_en_q && fifo_full && !rx_rst;
    end

    // Receiver and event enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q    <= 1'b0;
            stale_en_q <= 1'b0;
        end else begin
            if (rx_rst || (cmd_valid && cmd_code == CMD_RX_OFF)) rx_en_q <= 1'b0;
            else if (cmd_valid && cmd_code == CMD_RX_ON)         rx_en_q <= 1'b1;
            if (cmd_valid && cmd_code == CMD_STALE_ON)           stale_en_q <= 1'b1;
            else if (cmd_valid && cmd_code == CMD_STALE_OFF)     stale_en_q <= 1'b0;
        end
    end

    // Sticky event and overrun flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (xfer_end && stale_en_q)                          stale_q <= 1'b1;
            else if (cmd_valid && cmd_code == CMD_STALE_CLR)     stale_q <= 1'b0;
            if (drop)                                            ovr_q <= 1'b1;
            else if (cmd_valid && cmd_code == CMD_ERR_CLR)       ovr_q <= 1'b0;
        end
    end

    rx_stale_timer #(.TMR_W(TMR_W)) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_rst),
        .run       (stale_en_q && pending),
        .char_seen (accept),
        .tick      (char_tick),
        .limit     (stale_limit),
        .expire    (expire)
    );

    rx_xfer_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_rst),
        .accept   (accept),
        .expire   (expire),
        .len_wr   (len_wr),
        .len_val  (len_val),
        .xfer_end (xfer_end),
        .pending  (pending),
        .snap     (snap_count)
    );

    rx_word_packer #(.CHAR_W(CHAR_W), .WORD_W(WORD_W)) pack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_rst),
        .accept   (accept),
        .char_in  (char_data),
        .flush    (xfer_end),
        .push     (fifo_push),
        .word_out (fifo_data)
    );

    assign stale_evt = stale_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/uart_rx_packer_chk.sv
// Property checker for the receive word packer, bound to the top module.
module uart_rx_packer_chk
    import uart_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       char_valid,
    input logic       fifo_full,
    input logic       rx_en,
    input logic       stale_en,
    input logic       stale_evt,
    input logic       overrun,
    input logic       fifo_push
);
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !(cmd_valid && cmd_code == CMD_ERR_CLR) |=> overrun); // R7
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && rx_en && fifo_full && !(cmd_valid && cmd_code == CMD_RX_RESET) |=> overrun); // R7
    AST_STALE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !stale_evt && !stale_en |=> !stale_evt); // R3
    AST_STALE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == CMD_STALE_CLR && !stale_en |=> !stale_evt); // R3
    AST_RXRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_code == CMD_RX_RESET |=> !fifo_push && !rx_en); // R8
endmodule

bind uart_rx_packer uart_rx_packer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .char_valid (char_valid),
    .fifo_full  (fifo_full),
    .rx_en      (rx_en_q),
    .stale_en   (stale_en_q),
    .stale_evt  (stale_evt),
    .overrun    (overrun),
    .fifo_push  (fifo_push)
);

// File: tb/uart_rx_packer_tb_top.sv
// Self-checking bench: a vector table of transfers, then directed corner tests.
module uart_rx_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = '0;
    logic        char_tick = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = '0;
    logic [7:0]  stale_limit = 8'h0F;
    logic        len_wr = 1'b0;
    logic [15:0] len_val = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_push;
    logic [31:0] fifo_data;
    logic        stale_evt;
    logic [15:0] snap_count;
    logic        overrun;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int nwords = 0;
    logic [31:0] words [32];
    bit done = 0;

    localparam int NV = 6;
    localparam int          VEC_N    [NV] = '{1, 4, 5, 8, 3, 6};
    localparam logic [7:0]  VEC_BASE [NV] = '{8'h41, 8'h10, 8'hA0, 8'h01, 8'hF0, 8'h55};
    localparam logic [7:0]  VEC_TO   [NV] = '{8'd2, 8'd3, 8'd4, 8'd2, 8'd15, 8'd5};

    always #10 clk = ~clk;

    uart_rx_packer dut_i (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_tick(char_tick), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .stale_limit(stale_limit), .len_wr(len_wr), .len_val(len_val),
        .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_data(fifo_data),
        .stale_evt(stale_evt), .snap_count(snap_count), .overrun(overrun)
    );

    // Capture pushed words between edges.
    always @(negedge clk) begin
        if (fifo_push && nwords < 32) begin
            words[nwords] = fifo_data;
            nwords = nwords + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 200000 && !done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0; cmd_code = '0;
    endtask

    task automatic send_char(input logic [7:0] d);
        @(negedge clk); char_valid = 1'b1; char_data = d;
        @(negedge clk); char_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); char_tick = 1'b1;
            @(negedge clk); char_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_len(input logic [15:0] v);
        @(negedge clk); len_wr = 1'b1; len_val = v;
        @(negedge clk); len_wr = 1'b0;
    endtask

    initial begin
        idle(3);
        // R9: reset state
        check("R9 push", {31'b0, fifo_push}, 32'd0);
        check("R9 data", fifo_data, 32'd0);
        check("R9 stale", {31'b0, stale_evt}, 32'd0);
        check("R9 snap", {16'b0, snap_count}, 32'd0);
        check("R9 overrun", {31'b0, overrun}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        do_cmd(3'd2);
        do_cmd(3'd4);

        // Vector table: R1 packing, R4 zero fill, R5 snapshot, R2 timeout end
        for (int v = 0; v < NV; v++) begin
            nwords = 0;
            stale_limit = VEC_TO[v];
            for (int i = 0; i < VEC_N[v]; i++) begin
                send_char(8'(VEC_BASE[v] + 8'(i)));
                if (i < VEC_N[v] - 1) tick(1);
            end
            tick(int'(VEC_TO[v]));
            idle(2);
            check("R1 word count", nwords, (VEC_N[v] + 3) / 4);
            for (int w = 0; w < (VEC_N[v] + 3) / 4; w++) begin
                logic [31:0] e;
                e = '0;
                for (int b = 0; b < 4; b++)
                    if (w*4 + b < VEC_N[v]) e[b*8 +: 8] = 8'(VEC_BASE[v] + 8'(w*4 + b));
                check("R1/R4 word", words[w], e);
            end
            check("R5 snap", {16'b0, snap_count}, VEC_N[v]);
            check("R2 stale", {31'b0, stale_evt}, 32'd1);
            do_cmd(3'd6);
            check("R3 clear", {31'b0, stale_evt}, 32'd0);
        end

        // R2: exact tick and restart on character
        nwords = 0; stale_limit = 8'd3;
        send_char(8'h11); tick(2);
        send_char(8'h22); tick(2); idle(1);
        check("R2 early", {31'b0, stale_evt}, 32'd0);
        check("R2 no push early", nwords, 0);
        tick(1); idle(1);
        check("R2 on time", {31'b0, stale_evt}, 32'd1);
        check("R4 partial", words[0], 32'h0000_2211);
        check("R5 snap2", {16'b0, snap_count}, 32'd2);
        do_cmd(3'd6);

        // R2: limit 0 acts as 1
        nwords = 0; stale_limit = 8'd0;
        send_char(8'h99); tick(1); idle(1);
        check("R2 zero limit", {31'b0, stale_evt}, 32'd1);
        check("R2 zero limit word", words[0], 32'h0000_0099);
        do_cmd(3'd6);

        // R6: length limit ends transfer without ticks
        nwords = 0; stale_limit = 8'd4;
        arm_len(16'd6);
        for (int i = 0; i < 6; i++) send_char(8'(8'h30 + 8'(i)));
        idle(2);
        check("R6 words", nwords, 2);
        check("R6 word0", words[0], 32'h3332_3130);
        check("R6 word1", words[1], 32'h0000_3534);
        check("R6 snap", {16'b0, snap_count}, 32'd6);
        check("R6 stale", {31'b0, stale_evt}, 32'd1);
        do_cmd(3'd6);
        // R6: disarmed after end
        nwords = 0;
        for (int i = 0; i < 6; i++) send_char(8'(8'h40 + 8'(i)));
        idle(2);
        check("R6 disarmed", {31'b0, stale_evt}, 32'd0);
        check("R6 disarmed words", nwords, 1);
        tick(4); idle(1);
        check("R6 stale end", {16'b0, snap_count}, 32'd6);
        do_cmd(3'd6);

        // R3: timer idle while events disabled
        nwords = 0;
        do_cmd(3'd5);
        send_char(8'h5A); tick(20); idle(1);
        check("R3 disabled push", nwords, 0);
        check("R3 disabled evt", {31'b0, stale_evt}, 32'd0);
        do_cmd(3'd4);
        tick(4); idle(1);
        check("R3 enabled evt", {31'b0, stale_evt}, 32'd1);
        check("R3 enabled word", words[0], 32'h0000_005A);
        do_cmd(3'd6);

        // R7: overrun
        nwords = 0;
        fifo_full = 1'b1;
        send_char(8'hEE);
        fifo_full = 1'b0;
        idle(3);
        check("R7 set", {31'b0, overrun}, 32'd1);
        send_char(8'h12); tick(4); idle(1);
        check("R7 dropped", words[0], 32'h0000_0012);
        check("R7 snap", {16'b0, snap_count}, 32'd1);
        check("R7 sticky", {31'b0, overrun}, 32'd1);
        do_cmd(3'd7);
        check("R7 clear", {31'b0, overrun}, 32'd0);
        do_cmd(3'd6);

        // R8: receive reset
        nwords = 0;
        send_char(8'hA1); send_char(8'hA2);
        do_cmd(3'd1);
        send_char(8'hA3); tick(20); idle(1);
        check("R8 discard", nwords, 0);
        check("R8 no evt", {31'b0, stale_evt}, 32'd0);
        do_cmd(3'd2);
        send_char(8'h77); tick(4); idle(1);
        check("R8 fresh word", words[0], 32'h0000_0077);
        check("R8 snap", {16'b0, snap_count}, 32'd1);
        do_cmd(3'd3);
        nwords = 0;
        send_char(8'h78); tick(20); idle(1);
        check("R8 off", nwords, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule